// File: doc/BRIEF.md
# Four-Line Interrupt Router with Sticky Summary Latch

This block sits between a set of sixteen device interrupt sources and the interrupt controller above it. The sources arrive already latched and enabled. Each one carries a 2-bit route field, and that field sends it to one of four level-sensitive output lines. The route fields are split across two 32-bit route registers.

Next to the routing there is a second-level latch. It has one input bit, bit 11 of a read-only input register, which is the combined controller interrupt. That bit is gated by a mask register and accumulated into a sticky status register. A single summary output is high whenever that status register is nonzero.

A parameter selects between two variants:

- **Routed variant:** the device interrupts go only to the four lines. The summary path sees only the controller-internal interrupt.
- **Flat variant:** no routed lines exist. Every active interrupt, device or internal, is ORed into the summary path.

Software reaches the registers through a simple 32-bit port. Writes are synchronous and reads are combinational.

Top module: `irq_fanout_router`

## Requirements
- R1: Device i, for i from 0 to 13, takes its 2-bit route from bits [27-2i:26-2i] of the route register at offset 0x0C.
- R2: Device 14+k, for k from 0 to 1, takes its 2-bit route from bits [23-2k:22-2k] of the route register at offset 0x08.
- R3: In the routed variant, output line n is the OR of every active device whose route field equals n. The lines are levels and are not latched, so they follow `dev_irq` in the same cycle. A route register write takes effect from the next cycle.
- R4: In the routed variant, device interrupts do not reach the summary path. Bit 11 (0x800) of the input register at 0x5C equals `ctl_irq`.
- R5: In the flat variant (`ROUTE_EN`=0), bit 11 of the input register is the OR of `ctl_irq` and all device inputs. The four routed lines stay low whatever the route registers hold. The route registers still store and read back the written values.
- R6: On every clock the status register at 0x50 becomes (status & ~clear) | (input & mask). The mask is the register at 0x54. Clear is the data of a write to 0x50 in that cycle, so a 1 clears that bit. A bit that is still set by input and mask in the same cycle stays set.
- R7: `summary_irq` is high exactly when the status register is nonzero.
- R8: Writes to the input register at 0x5C have no effect, and it reads only bit 11. The polarity register at 0x58 reads back what was written and changes no output.
- R9: Reads at any other offset return 0xFFFFFFFF. Reset (synchronous, active high) clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| dev_irq | input | 16 | Latched and enabled device interrupts, one bit per device |
| ctl_irq | input | 1 | Combined controller-internal interrupt |
| route_out | output | 4 | Routed interrupt lines |
| summary_irq | output | 1 | High while the sticky status register is nonzero |

## Verification
The bench builds two instances side by side on the same stimulus: one with `ROUTE_EN`=1 and one with `ROUTE_EN`=0. This lets every pattern show both routing behaviour and flat-mode merging into the summary bit in the same cycle. The routed instance exercises field extraction at both ends of each route register and several devices sharing one line. The flat instance shows that device interrupts alone raise the summary output, and that route writes leave its lines low. Both instances are driven through a clear that collides with a still-active input, a clear after the input drops, and writes to the read-only and polarity registers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int NDEV    = 16;
    localparam int NLINE   = 4;
    localparam int RW      = 2;
    localparam int DW      = 32;
    localparam int AW      = 8;
    localparam int SUM_BIT = 11;
    localparam int LOW_CNT = 14;   // devices served by the 0x0C register

    localparam logic [AW-1:0] OFS_RT_A = 8'h08;
    localparam logic [AW-1:0] OFS_RT_B = 8'h0C;
    localparam logic [AW-1:0] OFS_STAT = 8'h50;
    localparam logic [AW-1:0] OFS_MASK = 8'h54;
    localparam logic [AW-1:0] OFS_POL  = 8'h58;
    localparam logic [AW-1:0] OFS_INP  = 8'h5C;

    typedef struct packed {
        logic [DW-1:0] rt_a;
        logic [DW-1:0] rt_b;
        logic [DW-1:0] mask;
        logic [DW-1:0] pol;
    } cfg_regs_t;

    typedef logic [RW-1:0] line_sel_t;

    // Route selector for one device: low devices from rt_b, the rest from rt_a.
    function automatic line_sel_t route_sel(input logic [DW-1:0] rt_a,
                                            input logic [DW-1:0] rt_b,
                                            input int dev);
        logic [DW-1:0] sh;
        if (dev < LOW_CNT) sh = rt_b >> (26 - 2 * dev);
        else               sh = rt_a >> (22 - 2 * (dev - LOW_CNT));
        return sh[RW-1:0];
    endfunction
endpackage

// File: rtl/irq_route_map.sv
module irq_route_map
    import irq_route_pkg::*;
#(
    parameter bit ROUTE_EN = 1'b1
) (
    input  logic [NDEV-1:0]  dev_irq,
    input  logic [DW-1:0]    rt_a,
    input  logic [DW-1:0]    rt_b,
    output logic [NLINE-1:0] line
);
    generate
        if (ROUTE_EN) begin : g_routed
            always_comb begin
                line = '0;
                for (int d = 0; d < NDEV; d++) begin
                    if (dev_irq[d]) line[route_sel(rt_a, rt_b, d)] = 1'b1;
                end
            end
        end else begin : g_flat
            logic unused_ok;
            assign unused_ok = ^{dev_irq, rt_a, rt_b};
            assign line      = '0;
        end
    endgenerate
endmodule

// File: rtl/irq_sticky_stat.sv
module irq_sticky_stat
    import irq_route_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] inp_vec,
    input  logic [DW-1:0] mask,
    input  logic          clr_we,
    input  logic [DW-1:0] clr_data,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] clr_vec;
    assign clr_vec = clr_we ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_vec) | (inp_vec & mask);
    end
endmodule

// File: rtl/irq_fanout_router.sv
module irq_fanout_router
    import irq_route_pkg::*;
#(
    parameter bit ROUTE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [15:0]      dev_irq,
    input  logic             ctl_irq,
    output logic [3:0]       route_out,
    output logic             summary_irq
);
    cfg_regs_t     cfg_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] inp_vec;
    logic [DW-1:0] mask_q;
    logic          merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_RT_A: cfg_q.rt_a <= reg_wdata;
                OFS_RT_B: cfg_q.rt_b <= reg_wdata;
                OFS_MASK: cfg_q.mask <= reg_wdata;
                OFS_POL:  cfg_q.pol  <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign mask_q = cfg_q.mask;

    generate
        if (ROUTE_EN) begin : g_sum_routed
            assign merged = ctl_irq;
        end else begin : g_sum_flat
            assign merged = ctl_irq | (|dev_irq);
        end
    endgenerate

    always_comb begin
        inp_vec          = '0;
        inp_vec[SUM_BIT] = merged;
    end

    irq_route_map #(.ROUTE_EN(ROUTE_EN)) u_map (
        .dev_irq (dev_irq),
        .rt_a    (cfg_q.rt_a),
        .rt_b    (cfg_q.rt_b),
        .line    (route_out)
    );

    irq_sticky_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .inp_vec  (inp_vec),
        .mask     (cfg_q.mask),
        .clr_we   (reg_we && (reg_addr == OFS_STAT)),
        .clr_data (reg_wdata),
        .stat_q   (stat_q)
    );

    assign summary_irq = |stat_q;

    always_comb begin
        case (reg_addr)
            OFS_RT_A: reg_rdata = cfg_q.rt_a;
            OFS_RT_B: reg_rdata = cfg_q.rt_b;
            OFS_STAT: reg_rdata = stat_q;
            OFS_MASK: reg_rdata = cfg_q.mask;
            OFS_POL:  reg_rdata = cfg_q.pol;
            OFS_INP:  reg_rdata = inp_vec;
            default:  reg_rdata = '1;
        endcase
    end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter bit ROUTE_EN = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [7:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [15:0]   dev_irq,
    input logic          ctl_irq,
    input logic [3:0]    route_out,
    input logic          summary_irq,
    input logic [DW-1:0] mask_q,
    input logic [DW-1:0] inp_vec
);
    // R3: a routed line is never high without an active device
    a_r3_line_has_source: assert property (@(posedge clk) disable iff (rst)
        (route_out != 4'b0) |-> (dev_irq != 16'b0));

    // R4: in the routed variant, devices do not drive the summary input bit
    a_r4_dev_kept_out: assert property (@(posedge clk) disable iff (rst)
        (ROUTE_EN && !ctl_irq) |-> !inp_vec[SUM_BIT]);

    // R5: in the flat variant, any device raises the summary input bit
    a_r5_flat_merge: assert property (@(posedge clk) disable iff (rst)
        (!ROUTE_EN && (dev_irq != 16'b0)) |-> inp_vec[SUM_BIT]);

    // R6: masked input latches into status, visible on the summary output
    a_r6_latch_sets: assert property (@(posedge clk) disable iff (rst)
        (inp_vec[SUM_BIT] && mask_q[SUM_BIT]) |=> summary_irq);

    // R6: status holds unless a clearing write hits it
    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (summary_irq && !(reg_we && reg_addr == OFS_STAT && reg_wdata[SUM_BIT]))
        |=> summary_irq);

    // R9: reset leaves the summary low
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> !summary_irq);
endmodule

bind irq_fanout_router irq_route_chk #(.ROUTE_EN(ROUTE_EN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .dev_irq     (dev_irq),
    .ctl_irq     (ctl_irq),
    .route_out   (route_out),
    .summary_irq (summary_irq),
    .mask_q      (mask_q),
    .inp_vec     (inp_vec)
);

// File: tb/irq_fanout_router_tb.sv
module irq_fanout_router_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [15:0] dev_irq = '0;
    logic        ctl_irq = 1'b0;
    logic [31:0] rd_r, rd_f;
    logic [3:0]  out_r, out_f;
    logic        sum_r, sum_f;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_fanout_router #(.ROUTE_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_r), .dev_irq(dev_irq),
        .ctl_irq(ctl_irq), .route_out(out_r), .summary_irq(sum_r));

    irq_fanout_router #(.ROUTE_EN(1'b0)) u_dut_flat (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_f), .dev_irq(dev_irq),
        .ctl_irq(ctl_irq), .route_out(out_f), .summary_irq(sum_f));

    // behavioural reference: index 0 = routed, 1 = flat
    logic [31:0] m_a, m_b, m_mask, m_pol;
    logic [31:0] m_stat [2];

    function automatic logic m_in(input int flat);
        return ctl_irq || (flat != 0 && dev_irq != 0);
    endfunction

    function automatic logic [3:0] m_lines(input int flat);
        logic [3:0] l = 4'b0;
        if (flat != 0) return l;
        for (int i = 0; i < 16; i++) begin
            int sel;
            if (i < 14) sel = int'((m_b >> (26 - 2*i)) & 32'h3);
            else        sel = int'((m_a >> (22 - 2*(i-14))) & 32'h3);
            if (dev_irq[i]) l[sel] = 1'b1;
        end
        return l;
    endfunction

    function automatic logic [31:0] m_read(input int flat);
        case (reg_addr)
            8'h08: return m_a;
            8'h0C: return m_b;
            8'h50: return m_stat[flat];
            8'h54: return m_mask;
            8'h58: return m_pol;
            8'h5C: return m_in(flat) ? 32'h800 : 32'h0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_a <= 0; m_b <= 0; m_mask <= 0; m_pol <= 0;
            m_stat[0] <= 0; m_stat[1] <= 0;
        end else begin
            for (int f = 0; f < 2; f++) begin
                logic [31:0] clr;
                clr = (reg_we && reg_addr == 8'h50) ? reg_wdata : 32'h0;
                m_stat[f] <= (m_stat[f] & ~clr) |
                             ((m_in(f) ? 32'h800 : 32'h0) & m_mask);
            end
            if (reg_we) begin
                if (reg_addr == 8'h08) m_a    <= reg_wdata;
                if (reg_addr == 8'h0C) m_b    <= reg_wdata;
                if (reg_addr == 8'h54) m_mask <= reg_wdata;
                if (reg_addr == 8'h58) m_pol  <= reg_wdata;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 routed lines", {28'b0, out_r}, {28'b0, m_lines(0)});
            chk("R5 flat lines",   {28'b0, out_f}, {28'b0, m_lines(1)});
            chk("R7 summary routed", {31'b0, sum_r}, {31'b0, m_stat[0] != 0});
            chk("R7 summary flat",   {31'b0, sum_f}, {31'b0, m_stat[1] != 0});
            chk("R9 read routed", rd_r, m_read(0));
            chk("R9 read flat",   rd_f, m_read(1));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd_at(input logic [7:0] a);
        reg_addr = a; #1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        step();
        // R9: reset state and unmapped reads
        rd_at(8'h08); chk("R9 reset route_a", rd_r, 32'h0);
        rd_at(8'h50); chk("R9 reset status", rd_r, 32'h0);
        chk("R7 reset summary", {31'b0, sum_r}, 32'h0);
        rd_at(8'h00); chk("R9 unmapped 0x00", rd_r, 32'hFFFF_FFFF);
        rd_at(8'h10); chk("R9 unmapped 0x10", rd_f, 32'hFFFF_FFFF);

        // R1/R2: dev0 -> line2 (bits 27:26), dev13 -> line3 (bits 1:0),
        // dev5 -> line1 (bits 17:16); dev14 -> line1 (23:22), dev15 -> line3 (21:20)
        wr(8'h0C, 32'h0801_0003);
        wr(8'h08, 32'h0070_0000);
        dev_irq = 16'h0001; #1;
        chk("R1 dev0 to line2", {28'b0, out_r}, 32'h4);
        dev_irq = 16'h2000; #1;
        chk("R1 dev13 to line3", {28'b0, out_r}, 32'h8);
        dev_irq = 16'h4000; #1;
        chk("R2 dev14 to line1", {28'b0, out_r}, 32'h2);
        dev_irq = 16'h8000; #1;
        chk("R2 dev15 to line3", {28'b0, out_r}, 32'h8);
        dev_irq = 16'h0022; #1;   // dev1 -> line0, dev5 -> line1
        chk("R3 shared pattern", {28'b0, out_r}, 32'h3);
        chk("R5 flat lines low", {28'b0, out_f}, 32'h0);
        step(); step();
        dev_irq = 16'h0000; #1;
        chk("R3 level drop", {28'b0, out_r}, 32'h0);
        rd_at(8'h0C); chk("R5 flat route readback", rd_f, 32'h0801_0003);

        // R4/R5/R6: mask on, device-only activity
        wr(8'h54, 32'h0000_0800);
        dev_irq = 16'h0100;
        step(); step();
        chk("R4 routed summary stays low", {31'b0, sum_r}, 32'h0);
        chk("R5 flat summary raised", {31'b0, sum_f}, 32'h1);
        rd_at(8'h5C); chk("R4 input reg routed", rd_r, 32'h0);
        chk("R5 input reg flat", rd_f, 32'h800);
        dev_irq = 16'h0000;
        step(); step();
        chk("R6 flat sticky", {31'b0, sum_f}, 32'h1);

        // R6: clear while input still active keeps bit; after drop clears
        ctl_irq = 1'b1;
        step(); step();
        chk("R6 routed set by ctl", {31'b0, sum_r}, 32'h1);
        wr(8'h50, 32'h0000_0800);
        chk("R6 clear loses to live input", {31'b0, sum_r}, 32'h1);
        ctl_irq = 1'b0;
        step();
        wr(8'h50, 32'h0000_0800);
        chk("R6 cleared routed", {31'b0, sum_r}, 32'h0);
        chk("R6 cleared flat", {31'b0, sum_f}, 32'h0);

        // R6: mask off blocks latching
        wr(8'h54, 32'h0);
        ctl_irq = 1'b1;
        step(); step();
        chk("R6 masked no latch", {31'b0, sum_r}, 32'h0);

        // R8: read-only input register and inert polarity register
        wr(8'h5C, 32'hFFFF_FFFF);
        rd_at(8'h5C); chk("R8 input reg ignores write", rd_r, 32'h800);
        wr(8'h58, 32'hA5A5_0800);
        rd_at(8'h58); chk("R8 polarity readback", rd_r, 32'hA5A5_0800);
        chk("R8 polarity inert", {31'b0, sum_r}, 32'h0);
        ctl_irq = 1'b0;
        step(); step();

        // R3: route rewrite takes effect next cycle
        dev_irq = 16'h0001;
        wr(8'h0C, 32'h0000_0000);
        #1 chk("R3 rewrite to line0", {28'b0, out_r}, 32'h1);
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule